// File: doc/BRIEF.md
# Multi-mode prescaled timer

This block is a 32-bit timer with a small synchronous register port. A power-of-two prescaler sets its tick rate, and one of eight modes decides what makes the count advance and what counts as an event. Every event sets a single interrupt flag, which drives the interrupt line. A timer output pin carries a toggle or PWM waveform, and the timer input pin feeds the external-event, gated and capture behaviours.

Software loads the compare value, and the PWM match value where the mode needs one. It then writes the control word with the enable bit set. One register has two roles. In PWM mode it holds the first-phase match value. In the capture-type modes and in compare mode the hardware writes the latched count into it.

Top module: `mtmr_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `tmr_out` are low.
- R2: The register byte offsets are: count 0x00, compare 0x04, PWM/capture 0x08, interrupt 0x0C, control 0x10. The control word uses these bits: mode [2:0], divider select bits 2..0 in [5:3], polarity [6], enable [7], divider select bit 3 in [8]. Control bits above 8 read back as 0.
- R3: In a clock-driven mode the count advances once every 2^sel clocks. The first advance comes 2^sel clocks after the write that enables the timer. A select value above 13 divides by 8192. While the timer is disabled the count holds.
- R4: In one-shot mode (mode 0), an advance taken while the count equals the compare value sets the count to 1, sets the flag and clears the enable bit. The timer then stays stopped.
- R5: Writing 1 to interrupt bit 0 clears the flag. Writing 0 has no effect. `irq` follows the flag.
- R6: In continuous mode (mode 1), the count steps 1, 2, ... up to the compare value and then wraps to 1. Each wrap sets the flag and toggles `tmr_out`, and the timer keeps running.
- R7: In PWM mode (mode 3) with polarity 0, `tmr_out` is low from the wrap until the end of the tick in which the count equals the PWM register. It is then high until the next wrap at the compare value, and the wrap sets the flag.
- R8: In capture mode (mode 4) and capture/compare mode (mode 7), an active edge on the synchronised input copies the count into the PWM/capture register and sets the flag. The active edge is rising when polarity is 0 and falling when polarity is 1. The opposite edge does nothing.
- R9: In counter mode (mode 2), the count advances once per active input edge, whatever the divider select.
- R10: In gated mode (mode 6), the count advances on prescaled ticks only while the synchronised input is at its active level (high when polarity is 0). An input held high for N clocks adds exactly N when the divider is 1.
- R11: In compare mode (mode 5), the wrap at the compare value copies the count into the PWM/capture register, sets the flag and toggles `tmr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tmr_in | input | 1 | Timer input pin (asynchronous) |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt, high while the flag is set |

## Verification
The embedded properties check, on every cycle, the following behaviours. The prescaler never ticks on two consecutive clocks at a divider above one. An input edge pulse lasts a single cycle. The count steps by exactly one or wraps to exactly 1. A one-shot wrap stops the timer. A capture latches the previous cycle's count. A write-one clear empties the flag. The directed scenarios are what show the absolute timing: the first advance after enabling, the clamping of a reserved divider select, the PWM phase boundary, the polarity-selected capture edge, and the exact gated count over a known input pulse.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

   typedef enum logic [2:0] {
      MD_ONESHOT = 3'd0,
      MD_CONT    = 3'd1,
      MD_EVCOUNT = 3'd2,
      MD_PWM     = 3'd3,
      MD_CAPTURE = 3'd4,
      MD_COMPARE = 3'd5,
      MD_GATED   = 3'd6,
      MD_CAPCMP  = 3'd7
   } tmr_mode_e;

   localparam int OFS_CNT  = 'h00;
   localparam int OFS_CMP  = 'h04;
   localparam int OFS_PC   = 'h08;
   localparam int OFS_INT  = 'h0C;
   localparam int OFS_CTRL = 'h10;

   localparam int CB_SEL_LO = 3;
   localparam int CB_POL    = 6;
   localparam int CB_EN     = 7;
   localparam int CB_SEL_HI = 8;
   localparam int CTRL_W    = 9;

endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
   parameter int SEL_W   = 4,
   parameter int SEL_MAX = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = (SEL_MAX < 1) ? 1 : SEL_MAX;

   if (SEL_MAX >= (1 << SEL_W)) begin : g_bad_sel
      $error("mtmr_prescaler: SEL_MAX does not fit in SEL_W bits");
   end

   logic [DIV_W-1:0] pcnt_q;
   logic [SEL_W-1:0] sel_eff;
   logic [DIV_W-1:0] mask;

   always_comb begin
      sel_eff = (sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel;
      mask    = (DIV_W'(1) << sel_eff) - DIV_W'(1);
   end

   assign tick = run && ((pcnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pcnt_q <= '0;
      else if (!run) pcnt_q <= '0;
      else          pcnt_q <= pcnt_q + DIV_W'(1);
   end

   // R3: above divide-by-1 two ticks are never adjacent unless the select moved
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_eff != '0) |=> (!tick || sel_eff != $past(sel_eff)));

endmodule

// File: rtl/mtmr_insync.sv
module mtmr_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic pol,
   output logic level,
   output logic act_edge
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mtmr_insync: at least two synchroniser stages are needed");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level    = chain_q[STAGES-1] ^ pol;
   assign act_edge = level && !(prev_q ^ pol);

   // R8: an edge pulse is a single cycle wide while the polarity is steady
   a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      act_edge |=> (!act_edge || pol != $past(pol)));

endmodule

// File: rtl/mtmr_timer.sv
module mtmr_timer
   import mtmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int ADDR_W      = 5,
   parameter int SEL_MAX     = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              tmr_in,
   output logic              tmr_out,
   output logic              irq
);
   localparam int SEL_W = $clog2(SEL_MAX + 1);

   if (CNT_W < 16) begin : g_bad_width
      $error("mtmr_timer: CNT_W must be at least 16");
   end
   if (SEL_W != 4) begin : g_bad_selw
      $error("mtmr_timer: the divider select must be four bits wide");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("mtmr_timer: ADDR_W must cover offset 0x10");
   end

   logic [CNT_W-1:0] cnt_q, cmp_q, pc_q;
   logic             flag_q, pol_q, en_q, out_q, phase_q;
   tmr_mode_e        mode_q;
   logic [SEL_W-1:0] sel_q;

   logic wr_cnt, wr_cmp, wr_pc, wr_int, wr_ctrl;
   logic tick, in_level, in_edge;
   logic adv, hit, cap_ev, cmp_ev, set_ev, toggles;

   assign wr_cnt  = reg_wr && (reg_addr == ADDR_W'(OFS_CNT));
   assign wr_cmp  = reg_wr && (reg_addr == ADDR_W'(OFS_CMP));
   assign wr_pc   = reg_wr && (reg_addr == ADDR_W'(OFS_PC));
   assign wr_int  = reg_wr && (reg_addr == ADDR_W'(OFS_INT));
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

   mtmr_prescaler #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en_q),
      .sel  (sel_q),
      .tick (tick)
   );

   mtmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (tmr_in),
      .pol     (pol_q),
      .level   (in_level),
      .act_edge(in_edge)
   );

   always_comb begin
      unique case (mode_q)
         MD_EVCOUNT: adv = en_q && in_edge;
         MD_GATED:   adv = en_q && tick && in_level;
         default:    adv = en_q && tick;
      endcase
      hit     = adv && (cnt_q == cmp_q);
      cap_ev  = en_q && in_edge && (mode_q == MD_CAPTURE || mode_q == MD_CAPCMP);
      cmp_ev  = hit && (mode_q == MD_COMPARE);
      set_ev  = cap_ev || (hit && mode_q != MD_CAPTURE);
      toggles = (mode_q == MD_CONT) || (mode_q == MD_EVCOUNT) ||
                (mode_q == MD_GATED) || (mode_q == MD_COMPARE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wr_cnt) cnt_q <= reg_wdata;
      else if (hit)    cnt_q <= CNT_W'(1);
      else if (adv)    cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_cmp) cmp_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pc_q <= '0;
      else if (wr_pc)             pc_q <= reg_wdata;
      else if (cap_ev || cmp_ev)  pc_q <= cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flag_q <= 1'b0;
      else if (set_ev)                   flag_q <= 1'b1;
      else if (wr_int && reg_wdata[0])   flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_ONESHOT;
         sel_q  <= '0;
         pol_q  <= 1'b0;
         en_q   <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q <= tmr_mode_e'(reg_wdata[2:0]);
         sel_q  <= {reg_wdata[CB_SEL_HI], reg_wdata[CB_SEL_LO +: 3]};
         pol_q  <= reg_wdata[CB_POL];
         en_q   <= reg_wdata[CB_EN];
      end else if (hit && mode_q == MD_ONESHOT) begin
         en_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              out_q <= 1'b0;
      else if (!en_q)          out_q <= 1'b0;
      else if (hit && toggles) out_q <= ~out_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   phase_q <= 1'b0;
      else if (!en_q || mode_q != MD_PWM)           phase_q <= 1'b0;
      else if (hit)                                 phase_q <= 1'b0;
      else if (adv && cnt_q == pc_q)                phase_q <= 1'b1;
   end

   assign tmr_out = pol_q ^ ((mode_q == MD_PWM) ? phase_q : out_q);
   assign irq     = flag_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_CNT):  reg_rdata = cnt_q;
         ADDR_W'(OFS_CMP):  reg_rdata = cmp_q;
         ADDR_W'(OFS_PC):   reg_rdata = pc_q;
         ADDR_W'(OFS_INT):  reg_rdata = CNT_W'(flag_q);
         ADDR_W'(OFS_CTRL): reg_rdata = CNT_W'({sel_q[3], en_q, pol_q, sel_q[2:0], mode_q});
         default:           reg_rdata = '0;
      endcase
   end

   // R6: a non-wrapping advance adds exactly one
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !hit && !wr_cnt) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R6: a wrap lands on one
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_cnt) |=> cnt_q == CNT_W'(1));

   // R4: a one-shot wrap stops the timer
   a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_q == MD_ONESHOT && !wr_ctrl) |=> !en_q);

   // R5: write-one clear empties the flag when no event competes
   a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_int && reg_wdata[0] && !set_ev) |=> !irq);

   // R8: a capture stores the count of the edge cycle and raises the flag
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev && !wr_pc) |=> (pc_q == $past(cnt_q) && irq));

endmodule

// File: tb/mtmr_timer_tb_top.sv
module mtmr_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tmr_in = 1'b0;
   logic        tmr_out, irq;

   int checks = 0;
   int errors = 0;

   localparam logic [4:0] A_CNT = 5'h00, A_CMP = 5'h04, A_PC = 5'h08,
                          A_INT = 5'h0C, A_CTRL = 5'h10;

   always #2 clk = ~clk;

   mtmr_timer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_in(tmr_in),
      .tmr_out(tmr_out), .irq(irq)
   );

   function automatic logic [31:0] ctl(input int md, input int sel, input bit pol, input bit en);
      logic [3:0] s = 4'(sel);
      return 32'(md & 7) | (32'(s[2:0]) << 3) | (32'(pol) << 6) | (32'(en) << 7) | (32'(s[3]) << 8);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input logic [31:0] cmpv, input logic [31:0] cntv, input logic [31:0] pcv);
      wr(A_CTRL, 32'h0);
      wr(A_INT, 32'h1);
      wr(A_CMP, cmpv);
      wr(A_CNT, cntv);
      wr(A_PC, pcv);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_CNT, v);  chk("R1 count", v, 0);
      rd(A_CMP, v);  chk("R1 compare", v, 0);
      rd(A_PC, v);   chk("R1 pwm/capture", v, 0);
      rd(A_INT, v);  chk("R1 flag", v, 0);
      rd(A_CTRL, v); chk("R1 control", v, 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 tmr_out", 32'(tmr_out), 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(A_CMP, 32'h1234_5678);
      wr(A_PC, 32'h0BAD_F00D);
      wr(A_CTRL, 32'hABCD_0000 | ctl(5, 9, 1, 0));
      rd(A_CMP, v);  chk("R2 compare", v, 32'h1234_5678);
      rd(A_PC, v);   chk("R2 pwm/capture", v, 32'h0BAD_F00D);
      rd(A_CTRL, v); chk("R2 control masked", v, 32'h14D);
   endtask

   task automatic t_prescale;
      logic [31:0] v;
      setup(32'hFFFF_FFFF, 0, 0);
      wr(A_CTRL, ctl(1, 0, 0, 1));
      wait_n(10);
      rd(A_CNT, v); chk("R3 div1", v, 10);
      setup(32'hFFFF_FFFF, 0, 0);
      wr(A_CTRL, ctl(1, 3, 0, 1));
      wait_n(39);
      rd(A_CNT, v); chk("R3 div8 before", v, 4);
      wait_n(1);
      rd(A_CNT, v); chk("R3 div8 fifth tick", v, 5);
      wr(A_CTRL, ctl(1, 3, 0, 0));
      wait_n(30);
      rd(A_CNT, v); chk("R3 disabled hold", v, 5);
      setup(32'hFFFF_FFFF, 0, 0);
      wr(A_CTRL, ctl(1, 15, 0, 1));
      wait_n(8191);
      rd(A_CNT, v); chk("R3 reserved sel before", v, 0);
      wait_n(1);
      rd(A_CNT, v); chk("R3 reserved sel = 8192", v, 1);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      setup(4, 0, 0);
      wr(A_CTRL, ctl(0, 0, 0, 1));
      wait_n(4);
      rd(A_CNT, v); chk("R4 count at compare", v, 4);
      chk("R4 no flag yet", 32'(irq), 0);
      wait_n(1);
      chk("R4 flag", 32'(irq), 1);
      rd(A_CNT, v); chk("R4 count reset", v, 1);
      rd(A_CTRL, v); chk("R4 enable cleared", v, ctl(0, 0, 0, 0));
      wait_n(6);
      rd(A_CNT, v); chk("R4 stays stopped", v, 1);
      wr(A_INT, 32'h0);
      chk("R5 write 0 keeps flag", 32'(irq), 1);
      wr(A_INT, 32'h1);
      chk("R5 write 1 clears", 32'(irq), 0);
      rd(A_INT, v); chk("R5 flag reg", v, 0);
   endtask

   task automatic t_cont;
      logic [31:0] v;
      setup(3, 0, 0);
      wr(A_CTRL, ctl(1, 0, 0, 1));
      wait_n(3);
      rd(A_CNT, v); chk("R6 count 3", v, 3);
      chk("R6 out before wrap", 32'(tmr_out), 0);
      wait_n(1);
      rd(A_CNT, v); chk("R6 wrap to 1", v, 1);
      chk("R6 flag", 32'(irq), 1);
      chk("R6 out toggled", 32'(tmr_out), 1);
      wait_n(3);
      chk("R6 out second toggle", 32'(tmr_out), 0);
      wait_n(2);
      rd(A_CNT, v); chk("R6 still running", v, 3);
   endtask

   task automatic t_pwm;
      logic [31:0] v;
      setup(6, 0, 2);
      wr(A_CTRL, ctl(3, 0, 0, 1));
      wait_n(2);
      chk("R7 first phase", 32'(tmr_out), 0);
      wait_n(1);
      chk("R7 second phase", 32'(tmr_out), 1);
      wait_n(3);
      chk("R7 second phase at compare", 32'(tmr_out), 1);
      chk("R7 no flag before wrap", 32'(irq), 0);
      wait_n(1);
      chk("R7 back to first phase", 32'(tmr_out), 0);
      chk("R7 wrap flag", 32'(irq), 1);
      rd(A_CNT, v); chk("R7 count wrap", v, 1);
   endtask

   task automatic t_capture;
      logic [31:0] v;
      setup(1000, 77, 0);
      wr(A_CTRL, ctl(4, 13, 0, 1));
      tmr_in = 1'b1; wait_n(6);
      rd(A_PC, v); chk("R8 rising capture", v, 77);
      chk("R8 capture flag", 32'(irq), 1);
      wr(A_INT, 32'h1);
      wr(A_CNT, 90);
      tmr_in = 1'b0; wait_n(6);
      rd(A_PC, v); chk("R8 falling ignored", v, 77);
      chk("R8 no flag on falling", 32'(irq), 0);
      wr(A_CTRL, ctl(4, 13, 1, 1));
      tmr_in = 1'b1; wait_n(6);
      rd(A_PC, v); chk("R8 pol1 rising ignored", v, 77);
      tmr_in = 1'b0; wait_n(6);
      rd(A_PC, v); chk("R8 pol1 falling capture", v, 90);
      chk("R8 pol1 flag", 32'(irq), 1);
   endtask

   task automatic t_counter;
      logic [31:0] v;
      setup(100, 0, 0);
      wr(A_CTRL, ctl(2, 13, 0, 1));
      for (int i = 0; i < 3; i++) begin
         tmr_in = 1'b1; wait_n(3);
         tmr_in = 1'b0; wait_n(3);
      end
      wait_n(3);
      rd(A_CNT, v); chk("R9 three edges", v, 3);
   endtask

   task automatic t_gated;
      logic [31:0] v;
      setup(1000, 0, 0);
      wr(A_CTRL, ctl(6, 0, 0, 1));
      wait_n(10);
      rd(A_CNT, v); chk("R10 inactive holds", v, 0);
      tmr_in = 1'b1; wait_n(12);
      tmr_in = 1'b0; wait_n(6);
      rd(A_CNT, v); chk("R10 gated count", v, 12);
   endtask

   task automatic t_compare;
      logic [31:0] v;
      setup(5, 0, 0);
      wr(A_CTRL, ctl(5, 0, 0, 1));
      wait_n(5);
      chk("R11 no flag before match", 32'(irq), 0);
      wait_n(1);
      rd(A_PC, v); chk("R11 count copied", v, 5);
      chk("R11 flag", 32'(irq), 1);
      chk("R11 out toggled", 32'(tmr_out), 1);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_prescale;
      t_oneshot;
      t_cont;
      t_pwm;
      t_capture;
      t_counter;
      t_gated;
      t_compare;
      finish_run;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end
endmodule